// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block holds the interrupt status word of an SD host controller together with two mask words: one that decides which events get recorded, and one that decides which recorded events drive the interrupt line. The command engine, the data path and the DMA logic each deliver single-cycle event pulses. A pulse is latched into its status bit when the matching recording-enable bit is set. Software clears status bits by writing ones to them.

The status word is split into two halves. The lower half holds the normal events. The upper half holds the individual error events. The top bit of the lower half is a summary flag. Software cannot write it. It reads as the OR of every latched error bit.

A single interrupt output is driven from the status word ANDed with the signalling-enable word. A small register port gives read and write access to all three words. With the default 32-bit width, normal events occupy bits 14:0, the summary flag is bit 15 and error events occupy bits 31:16.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset the status, recording-enable and signalling-enable words all read as zero, and `irq_o` is low.
- R2: A pulse on an event input whose recording-enable bit is set sets the matching status bit at the next clock edge. Normal event input i maps to status bit i. Error event input j maps to status bit 16+j. The named positions are: bit 0 command done, bit 1 transfer done, bit 3 DMA boundary, bit 4 buffer write ready, bit 5 buffer read ready, bit 16 command timeout. On the register port, address 0 is status, address 1 is recording-enable and address 2 is signalling-enable.
- R3: A pulse whose recording-enable bit is clear leaves the status word unchanged.
- R4: A write to address 0 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R5: Status bit 15 reads as the OR of status bits 31:16. Writing a 1 to it has no effect of its own. Recording-enable bit 15 always reads 0.
- R6: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: `irq_o` is registered. In each cycle it equals the OR of (status AND signalling-enable) as those words stood in the previous cycle.
- R8: Clearing a recording-enable bit does not clear a status bit that is already latched.
- R9: A read of address 3 returns zero, and a write to it changes no word.
- R10: The signalling-enable word takes every written bit. The recording-enable word takes every written bit except bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all words |
| norm_evt_i | input | 15 | Normal event pulses, bit i targets status bit i |
| err_evt_i | input | 16 | Error event pulses, bit j targets status bit 16+j |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 status, 1 recording-enable, 2 signalling-enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected word, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default 32-bit word and the registered interrupt variant. This places the summary flag at bit 15 and gives every normal and error position a real input. At that width, directed sequences reach the summary flag rising and falling with the upper half, a clear colliding with an event, and the one-cycle interrupt lag after both enable writes and clears. A stretch of random pulses and writes then runs while the outputs are compared against the behavioural model on every cycle.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

   typedef enum logic [1:0] {
      SEL_STATUS  = 2'd0,
      SEL_REC_EN  = 2'd1,
      SEL_SIG_EN  = 2'd2,
      SEL_UNUSED  = 2'd3
   } sdh_irq_sel_e;

   localparam int unsigned POS_CMD_DONE   = 0;
   localparam int unsigned POS_XFER_DONE  = 1;
   localparam int unsigned POS_DMA_BNDRY  = 3;
   localparam int unsigned POS_BUF_WR_RDY = 4;
   localparam int unsigned POS_BUF_RD_RDY = 5;

endpackage

// File: rtl/sdh_irq_w1c_bank.sv
module sdh_irq_w1c_bank #(
   parameter int unsigned W       = 32,
   parameter int unsigned SUM_POS = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] stat_o
);
   logic [W-1:0] held;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == SUM_POS) begin : g_sum
         // derived flag: no storage, follows the upper half
         assign held[i]   = 1'b0;
         assign stat_o[i] = |held[W-1:SUM_POS+1];
      end else begin : g_flop
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= (q & ~clr_i[i]) | set_i[i];  // set beats clear
         end
         assign held[i]   = q;
         assign stat_o[i] = q;
      end
   end
endmodule

// File: rtl/sdh_irq_en_reg.sv
module sdh_irq_en_reg #(
   parameter int unsigned  W     = 32,
   parameter logic [W-1:0] WMASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (we_i) q_o <= wdata_i & WMASK;
   end
endmodule

// File: rtl/sdh_irq_out.sv
module sdh_irq_out #(
   parameter int unsigned W       = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] stat_i,
   input  logic [W-1:0] en_i,
   output logic         irq_o
);
   logic hit;
   assign hit = |(stat_i & en_i);

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= hit;
      end
   end else begin : g_comb
      assign irq_o = hit;
   end
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status #(
   parameter int unsigned REG_W   = 32,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned ERR_LSB = REG_W / 2,
   localparam int unsigned SUM_POS = ERR_LSB - 1,
   localparam int unsigned NORM_W  = SUM_POS,
   localparam int unsigned ERR_W   = REG_W - ERR_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NORM_W-1:0] norm_evt_i,
   input  logic [ERR_W-1:0]  err_evt_i,
   input  logic              wr_en_i,
   input  logic [1:0]        addr_i,
   input  logic [REG_W-1:0]  wdata_i,
   output logic [REG_W-1:0]  rdata_o,
   output logic              irq_o
);
   import sdh_irq_pkg::*;

   if ((REG_W < 4) || (REG_W % 2 != 0)) begin : g_bad_width
      $error("sdh_irq_status: REG_W must be even and at least 4");
   end

   localparam logic [REG_W-1:0] REC_MASK = ~(REG_W'(1) << SUM_POS);

   sdh_irq_sel_e      sel;
   logic [REG_W-1:0]  evt_all, set_v, clr_v, stat_v, rec_en, sig_en;
   logic              we_rec, we_sig;

   assign sel     = sdh_irq_sel_e'(addr_i);
   assign evt_all = {err_evt_i, 1'b0, norm_evt_i};
   assign set_v   = evt_all & rec_en;
   assign clr_v   = (wr_en_i && sel == SEL_STATUS) ? wdata_i : '0;
   assign we_rec  = wr_en_i && sel == SEL_REC_EN;
   assign we_sig  = wr_en_i && sel == SEL_SIG_EN;

   sdh_irq_w1c_bank #(.W(REG_W), .SUM_POS(SUM_POS)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .stat_o(stat_v)
   );

   sdh_irq_en_reg #(.W(REG_W), .WMASK(REC_MASK)) u_rec (
      .clk(clk), .rst_n(rst_n), .we_i(we_rec), .wdata_i(wdata_i), .q_o(rec_en)
   );

   sdh_irq_en_reg #(.W(REG_W), .WMASK('1)) u_sig (
      .clk(clk), .rst_n(rst_n), .we_i(we_sig), .wdata_i(wdata_i), .q_o(sig_en)
   );

   sdh_irq_out #(.W(REG_W), .OUT_REG(OUT_REG)) u_out (
      .clk(clk), .rst_n(rst_n), .stat_i(stat_v), .en_i(sig_en), .irq_o(irq_o)
   );

   always_comb begin
      unique case (sel)
         SEL_STATUS: rdata_o = stat_v;
         SEL_REC_EN: rdata_o = rec_en;
         SEL_SIG_EN: rdata_o = sig_en;
         default:    rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/sdh_irq_status_chk.sv
module sdh_irq_status_chk #(
   parameter int unsigned W       = 32,
   parameter int unsigned SUM_POS = 15,
   parameter bit          OUT_REG = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] set_v,
   input logic [W-1:0] clr_v,
   input logic [W-1:0] stat_v,
   input logic [W-1:0] sig_en,
   input logic         irq_o
);
   localparam logic [W-1:0] NOSUM = ~(W'(1) << SUM_POS);

   // R2: an enabled event is latched at the next edge
   assert_evt_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_v & $past(set_v)) == $past(set_v)));

   // R3: no bit appears without a recorded event
   assert_no_stray_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_v & ~$past(stat_v) & ~$past(set_v) & NOSUM) == '0));

   // R4: a written one without a colliding event clears the bit
   assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_v & $past(clr_v & ~set_v) & NOSUM) == '0));

   // R5: summary flag mirrors the upper half
   assert_summary_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_v[SUM_POS] == (|stat_v[W-1:SUM_POS+1])));

   // R6: event wins over a simultaneous clear
   assert_evt_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_v & $past(set_v & clr_v)) == $past(set_v & clr_v)));

   if (OUT_REG) begin : g_irq_reg
      // R7: interrupt lags the masked status by one cycle
      assert_irq_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_o == $past(|(stat_v & sig_en))));
   end
endmodule

bind sdh_irq_status sdh_irq_status_chk #(
   .W(REG_W), .SUM_POS(SUM_POS), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v),
   .stat_v(stat_v), .sig_en(sig_en), .irq_o(irq_o)
);

// File: tb/sim_sdh_irq_status.sv
module sim_sdh_irq_status;
   import sdh_irq_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] norm_evt = '0;
   logic [15:0] err_evt = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [31:0] m_stat = '0, m_rec = '0, m_sig = '0;
   logic        m_irq = 1'b0;

   always #10 clk = ~clk;

   sdh_irq_status u0 (
      .clk(clk), .rst_n(rst_n), .norm_evt_i(norm_evt), .err_evt_i(err_evt),
      .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   function automatic logic [31:0] view(input logic [31:0] s);
      logic [31:0] v;
      v = s & ~32'h0000_8000;
      v[15] = |s[31:16];
      return v;
   endfunction

   function automatic logic [31:0] model_read(input logic [1:0] a);
      case (a)
         2'd0:    return view(m_stat);
         2'd1:    return m_rec;
         2'd2:    return m_sig;
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h want %08h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      string tag;
      check("R7", {31'd0, irq}, {31'd0, m_irq});
      case (addr)
         2'd0: tag = "R2";
         2'd3: tag = "R9";
         default: tag = "R10";
      endcase
      check(tag, rdata, model_read(addr));
   endtask

   // one clock: model follows the edge, outputs compared at the falling edge
   task automatic step();
      logic        nirq;
      logic [31:0] gated;
      @(posedge clk);
      if (rst_n) begin
         nirq  = |(view(m_stat) & m_sig);
         gated = {err_evt, 1'b0, norm_evt} & m_rec;
         if (wr_en && addr == 2'd0) m_stat = m_stat & ~wdata;
         m_stat = (m_stat | gated) & ~32'h0000_8000;
         if (wr_en && addr == 2'd1) m_rec = wdata & ~32'h0000_8000;
         if (wr_en && addr == 2'd2) m_sig = wdata;
         m_irq = nirq;
      end
      @(negedge clk);
      compare_all();
      norm_evt = '0;
      err_evt  = '0;
      wr_en    = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      step();
   endtask

   task automatic peek(input string req, input logic [1:0] a, input logic [31:0] exp);
      addr = a;
      #1;
      check(req, rdata, exp);
   endtask

   initial begin
      repeat (3) step();
      // R1: reset state
      peek("R1", 2'd0, 32'h0);
      peek("R1", 2'd1, 32'h0);
      peek("R1", 2'd2, 32'h0);
      check("R1", {31'd0, irq}, 32'h0);
      rst_n = 1'b1;
      step();

      // R10 / R5: enable words
      wr(2'd1, 32'hFFFF_FFFF);
      peek("R5", 2'd1, 32'hFFFF_7FFF);
      wr(2'd2, 32'h0);
      peek("R10", 2'd2, 32'h0);

      // R2: command, transfer, DMA boundary
      norm_evt[POS_CMD_DONE] = 1'b1;
      norm_evt[POS_XFER_DONE] = 1'b1;
      norm_evt[POS_DMA_BNDRY] = 1'b1;
      step();
      peek("R2", 2'd0, 32'h0000_000B);

      // R7: interrupt follows the enable write one cycle later
      wr(2'd2, 32'h0000_0002);
      check("R7", {31'd0, irq}, 32'h0);
      step();
      check("R7", {31'd0, irq}, 32'h1);

      // R4: clear transfer done only
      wr(2'd0, 32'h0000_0002);
      peek("R4", 2'd0, 32'h0000_0009);
      step();
      check("R7", {31'd0, irq}, 32'h0);

      // R2 / R5: command timeout raises the summary
      err_evt[0] = 1'b1;
      step();
      peek("R5", 2'd0, 32'h0001_8009);
      wr(2'd0, 32'h0000_8000);
      peek("R5", 2'd0, 32'h0001_8009);
      wr(2'd0, 32'h0001_0000);
      peek("R5", 2'd0, 32'h0000_0009);

      // R3: disabled buffer events are dropped
      wr(2'd1, 32'h0000_0001);
      norm_evt[POS_BUF_WR_RDY] = 1'b1;
      norm_evt[POS_BUF_RD_RDY] = 1'b1;
      err_evt[3] = 1'b1;
      step();
      peek("R3", 2'd0, 32'h0000_0009);
      wr(2'd1, 32'h0000_0031);
      norm_evt[POS_BUF_WR_RDY] = 1'b1;
      norm_evt[POS_BUF_RD_RDY] = 1'b1;
      step();
      peek("R2", 2'd0, 32'h0000_0039);

      // R6: event and clear on the same bit
      norm_evt[POS_CMD_DONE] = 1'b1;
      wr(2'd0, 32'h0000_0001);
      peek("R6", 2'd0, 32'h0000_0039);

      // R8: dropping the enable keeps latched bits
      wr(2'd1, 32'h0);
      peek("R8", 2'd0, 32'h0000_0039);

      // R9: unused address
      wr(2'd3, 32'hFFFF_FFFF);
      peek("R9", 2'd3, 32'h0);
      peek("R9", 2'd0, 32'h0000_0039);
      peek("R9", 2'd1, 32'h0);

      // random traffic, model compared every clock
      for (int k = 0; k < 400; k++) begin
         if ($urandom_range(0, 2) == 0) norm_evt = 15'($urandom);
         if ($urandom_range(0, 3) == 0) err_evt  = 16'($urandom);
         addr = 2'($urandom);
         if ($urandom_range(0, 3) == 0) begin
            wr_en = 1'b1;
            wdata = $urandom;
         end
         step();
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got hung want done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule